// File: doc/BRIEF.md
# SMBus Block Transfer Sequencer

This block sits behind a byte-wide host register file and runs the block-transfer side of an SMBus host. Software loads a byte count, an optional offset and the bytes to send, then writes a start bit. The block then drives a simple one-operation-per-cycle request port toward a serial engine. The serial engine answers in the same cycle with an acknowledge and a data byte. Serial bus timing lives in that engine and is not part of this block.

Two transfer styles share one 32-entry byte buffer. An auxiliary control bit picks between them. In buffered mode, software fills or drains the whole buffer through the block-data register, and an auto-incrementing index tracks its place. In byte-by-byte mode, one byte at a time passes through a holding register, and software paces each step by writing 1 to clear the byte-done status flag. A third variant, the I2C block read, first sends an offset byte and then receives bytes one at a time. It ends with a NACK on the final byte.

An internal done flag is set at reset and after every completion. While it is set, a clear of byte-done moves nothing. Completion is found by comparing the buffer index with the count register.

Top module: `smbseq_top`

## Requirements
- R1: The auxiliary register (address 5) keeps only bits [1:0]. Bit 1 selects buffered mode and bit 0 is the PEC enable. Upper bits read back as zero.
- R2: A write to block data (address 4) behaves differently by mode. In buffered mode it stores the byte at the current index and then increments the index. In byte-by-byte mode it loads the holding byte instead, and a read of address 4 returns that holding byte.
- R3: After index DEPTH-1, the index continues at 0. With a 33rd buffered write, the byte lands at entry 0.
- R4: A buffered write start with the direction bit (control bit 4) clear requires the index to equal the count (address 2) taken modulo DEPTH, with the count no larger than DEPTH. If it does not, the index returns to 0, device error (status bit 2) is set and busy (status bit 0) clears. If it does, the block issues count SEND requests (bus_op 0) carrying entries 0, 1, ... with bus_last on the final one. It then sets the interrupt flag (status bit 1) and clears busy.
- R5: A buffered read start with control bit 4 set works in stages. The block first issues RCOUNT (bus_op 1) and takes the returned count into address 2. It then issues that many RBYTE requests (bus_op 2) that fill the buffer, and then sets the interrupt flag while busy stays set. Each read of address 4 returns the next entry. The read that brings the index up to the count clears busy and returns the index to 0.
- R6: A byte-by-byte start sets busy and byte-done (status bit 7). Each write of 1 to status bit 7 while the operation is unfinished advances the index by one.
- R7: A byte-by-byte write works as follows. The start copies the holding byte into entry 0. Each advance that does not reach the count copies the holding byte into the new entry and sets byte-done again. The advance that reaches the count sends the buffer as in R4, then sets the interrupt flag and clears busy.
- R8: In a byte-by-byte read, each advance presents the next buffer entry as the holding byte and sets byte-done again. If last-byte (control bit 2) is set, that advance instead ends the operation, sets the interrupt flag and clears busy.
- R9: An I2C block read (control bit 3) ignores the direction bit. It issues OFFSET (bus_op 3) carrying the offset register (address 3), then RECV (bus_op 4) for the first byte. Each advance issues a further RECV. An advance with last-byte set raises bus_last (the NACK) and ends the operation.
- R10: A start written while an operation is unfinished first abandons it and returns the index to 0. If the abandoned operation was an I2C read, the block issues STOP (bus_op 5) in that cycle.
- R11: Writing kill (control bit 1) ends any operation in the same cycle. It sets failed (status bit 3) and clears busy.
- R12: A write of 1 to byte-done while no operation is unfinished clears the flag and does nothing else: no bus request and no index change.
- R13: Reset clears all status and control. Status bits 1, 2, 3 and 7 clear when 1 is written to them, and busy cannot be written. A start while device error is set fails at once, with no bus request. irq equals control bit 0 AND any of status bits 1, 2, 3 or 7.
- R14: An RCOUNT answer that is not acknowledged, or that is larger than DEPTH, sets device error, clears busy and ends the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on block data) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from state |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Serial engine operation request |
| bus_op | output | 3 | Operation code |
| bus_wdata | output | 8 | Byte to send (0 for receive operations) |
| bus_last | output | 1 | Final byte of a send, fill or receive |
| bus_ack | input | 1 | Same-cycle acknowledge from the engine |
| bus_rdata | input | 8 | Same-cycle byte or count from the engine |

## Verification
Register writes and block-data reads take effect at the edge that samples the strobe, so the status is already new on the following cycle. A bus request made from a register access (STOP, a byte-by-byte RECV, or an advance) appears in the same cycle as the strobe. A start always reaches the launch step one cycle later. Buffer sends and fills then run one byte per cycle, and the buffered-read handoff adds one more cycle. The scoreboard queues each expected request before the stimulus that causes it, and the monitor compares every request in the cycle it is raised, between clock edges. Status and data checks wait a bounded number of cycles that covers the whole sequence, or poll busy, and only then sample.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;
    localparam logic [3:0] RA_STS  = 4'd0;
    localparam logic [3:0] RA_CTL  = 4'd1;
    localparam logic [3:0] RA_CNT  = 4'd2;
    localparam logic [3:0] RA_OFS  = 4'd3;
    localparam logic [3:0] RA_BDAT = 4'd4;
    localparam logic [3:0] RA_AUX  = 4'd5;

    localparam int CB_IEN  = 0;
    localparam int CB_KILL = 1;
    localparam int CB_LAST = 2;
    localparam int CB_I2C  = 3;
    localparam int CB_RD   = 4;
    localparam int CB_GO   = 6;

    localparam int SB_BUSY  = 0;
    localparam int SB_INTR  = 1;
    localparam int SB_DERR  = 2;
    localparam int SB_FAIL  = 3;
    localparam int SB_BDONE = 7;

    localparam int AB_PEC = 0;
    localparam int AB_BUF = 1;

    typedef enum logic [2:0] {
        BOP_SEND   = 3'd0,
        BOP_RCOUNT = 3'd1,
        BOP_RBYTE  = 3'd2,
        BOP_OFFSET = 3'd3,
        BOP_RECV   = 3'd4,
        BOP_STOP   = 3'd5
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_I2CRX  = 3'd2,
        ST_FILL   = 3'd3,
        ST_FINR   = 3'd4,
        ST_SEND   = 3'd5
    } seq_st_e;
endpackage

// File: rtl/smbseq_store.sv
module smbseq_store #(
    parameter int DEPTH = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [7:0]    rdata_a,
    output logic [7:0]    rdata_b
);
    logic [7:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= 8'h00;
            end else if (we && (waddr == IW'(g))) begin
                ent_q[g] <= wdata;
            end
        end
    end

    assign rdata_a = ent_q[raddr_a];
    assign rdata_b = ent_q[raddr_b];
endmodule

// File: rtl/smbseq_ctrl.sv
module smbseq_ctrl
    import smbseq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic [7:0]    buf_a,
    input  logic [7:0]    buf_b,
    input  logic          bus_ack,
    input  logic [7:0]    bus_rdata,
    output logic          mem_we,
    output logic [IW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [IW-1:0] rd_idx,
    output logic [IW-1:0] rd_idx_nx,
    output logic          bus_req,
    output bus_op_e       bus_op,
    output logic [7:0]    bus_wdata,
    output logic          bus_last,
    output logic [7:0]    sts_o,
    output logic [4:0]    ctl_o,
    output logic [7:0]    cnt_o,
    output logic [7:0]    ofs_o,
    output logic [7:0]    hold_o,
    output logic [1:0]    aux_o,
    output logic          blk_path_o
);
    typedef struct packed {
        seq_st_e       st;
        logic [IW-1:0] idx;
        logic          done;
        logic          i2c;
        logic [4:0]    ctl;
        logic [7:0]    cnt;
        logic [7:0]    ofs;
        logic [7:0]    hold;
        logic [1:0]    aux;
        logic          busy;
        logic          intr;
        logic          derr;
        logic          fail;
        logic          bdone;
    } seq_t;

    seq_t q, d;

    logic [IW-1:0] idx_nx;
    logic          cnt_ok;
    logic          hit_nx;
    logic          hit_cur;
    logic          last_of_cnt;
    logic          adv_rd;

    always_comb begin
        idx_nx      = (q.idx == IW'(DEPTH - 1)) ? '0 : q.idx + 1'b1;
        cnt_ok      = (q.cnt <= 8'(DEPTH));
        hit_nx      = cnt_ok && (idx_nx == q.cnt[IW-1:0]);
        hit_cur     = cnt_ok && (q.idx == q.cnt[IW-1:0]);
        last_of_cnt = ((9'(q.idx) + 9'd1) == 9'(q.cnt));
        adv_rd      = q.i2c || q.ctl[CB_RD];
    end

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = q.idx;
        mem_wdata = 8'h00;
        bus_req   = 1'b0;
        bus_op    = BOP_SEND;
        bus_wdata = 8'h00;
        bus_last  = 1'b0;

        // sequencer steps
        case (q.st)
            ST_LAUNCH: begin
                if (q.derr) begin
                    d.busy = 1'b0;
                    d.st   = ST_IDLE;
                end else if (q.ctl[CB_I2C]) begin
                    bus_req   = 1'b1;
                    bus_op    = BOP_OFFSET;
                    bus_wdata = q.ofs;
                    if (bus_ack) begin
                        d.st = ST_I2CRX;
                    end else begin
                        d.derr = 1'b1;
                        d.busy = 1'b0;
                        d.st   = ST_IDLE;
                    end
                end else if (q.ctl[CB_RD]) begin
                    bus_req = 1'b1;
                    bus_op  = BOP_RCOUNT;
                    d.idx   = '0;
                    if (!bus_ack || (bus_rdata > 8'(DEPTH))) begin
                        d.derr = 1'b1;
                        d.busy = 1'b0;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = bus_rdata;
                        d.st  = (bus_rdata == 8'h00) ? ST_FINR : ST_FILL;
                    end
                end else if (q.aux[AB_BUF]) begin
                    d.idx = '0;
                    if (hit_cur) begin
                        d.st = ST_SEND;
                    end else begin
                        d.derr = 1'b1;
                        d.busy = 1'b0;
                        d.st   = ST_IDLE;
                    end
                end else begin
                    mem_we    = 1'b1;
                    mem_waddr = '0;
                    mem_wdata = q.hold;
                    d.idx     = '0;
                    d.done    = 1'b0;
                    d.bdone   = 1'b1;
                    d.st      = ST_IDLE;
                end
            end
            ST_I2CRX: begin
                bus_req = 1'b1;
                bus_op  = BOP_RECV;
                d.hold  = bus_rdata;
                d.i2c   = 1'b1;
                d.done  = 1'b0;
                d.bdone = 1'b1;
                d.idx   = '0;
                d.st    = ST_IDLE;
            end
            ST_FILL: begin
                bus_req   = 1'b1;
                bus_op    = BOP_RBYTE;
                bus_last  = last_of_cnt;
                mem_we    = 1'b1;
                mem_waddr = q.idx;
                mem_wdata = bus_rdata;
                if (last_of_cnt) begin
                    d.idx = '0;
                    d.st  = ST_FINR;
                end else begin
                    d.idx = idx_nx;
                end
            end
            ST_FINR: begin
                d.idx = '0;
                d.st  = ST_IDLE;
                if (q.aux[AB_BUF]) begin
                    d.intr = 1'b1;
                    if (q.cnt == 8'h00) begin
                        d.done = 1'b1;
                        d.busy = 1'b0;
                    end else begin
                        d.done = 1'b0;
                    end
                end else begin
                    d.hold  = buf_a;
                    d.done  = 1'b0;
                    d.bdone = 1'b1;
                end
            end
            ST_SEND: begin
                if (q.cnt == 8'h00) begin
                    d.done = 1'b1;
                    d.intr = 1'b1;
                    d.busy = 1'b0;
                    d.idx  = '0;
                    d.st   = ST_IDLE;
                end else begin
                    bus_req   = 1'b1;
                    bus_op    = BOP_SEND;
                    bus_wdata = buf_a;
                    bus_last  = last_of_cnt;
                    if (!bus_ack) begin
                        d.derr = 1'b1;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.idx  = '0;
                        d.st   = ST_IDLE;
                    end else if (last_of_cnt) begin
                        d.done = 1'b1;
                        d.intr = 1'b1;
                        d.busy = 1'b0;
                        d.idx  = '0;
                        d.st   = ST_IDLE;
                    end else begin
                        d.idx = idx_nx;
                    end
                end
            end
            default: ;
        endcase

        // register writes
        if (reg_wr) begin
            case (reg_addr)
                RA_STS: begin
                    d.intr  = d.intr  & ~reg_wdata[SB_INTR];
                    d.derr  = d.derr  & ~reg_wdata[SB_DERR];
                    d.fail  = d.fail  & ~reg_wdata[SB_FAIL];
                    d.bdone = d.bdone & ~reg_wdata[SB_BDONE];
                    if (q.bdone && reg_wdata[SB_BDONE] && !q.done &&
                        (q.i2c || !q.aux[AB_BUF])) begin
                        if (!adv_rd && hit_nx) begin
                            d.idx = '0;
                            d.st  = ST_SEND;
                        end else if (!adv_rd) begin
                            mem_we    = 1'b1;
                            mem_waddr = idx_nx;
                            mem_wdata = q.hold;
                            d.idx     = idx_nx;
                            d.bdone   = 1'b1;
                        end else if (q.ctl[CB_LAST]) begin
                            if (q.i2c) begin
                                bus_req  = 1'b1;
                                bus_op   = BOP_RECV;
                                bus_last = 1'b1;
                                d.hold   = bus_rdata;
                                d.i2c    = 1'b0;
                            end else begin
                                d.hold = buf_b;
                            end
                            d.done = 1'b1;
                            d.idx  = '0;
                            d.intr = 1'b1;
                            d.busy = 1'b0;
                        end else begin
                            if (q.i2c) begin
                                bus_req = 1'b1;
                                bus_op  = BOP_RECV;
                                d.hold  = bus_rdata;
                            end else begin
                                d.hold = buf_b;
                            end
                            d.idx   = idx_nx;
                            d.bdone = 1'b1;
                        end
                    end
                end
                RA_CTL: begin
                    d.ctl = reg_wdata[4:0];
                    if (reg_wdata[CB_GO]) begin
                        if (!q.done) begin
                            d.idx  = '0;
                            d.done = 1'b1;
                            if (q.i2c) begin
                                bus_req   = 1'b1;
                                bus_op    = BOP_STOP;
                                bus_wdata = 8'h00;
                                bus_last  = 1'b0;
                                d.i2c     = 1'b0;
                            end
                        end
                        d.busy = 1'b1;
                        d.st   = ST_LAUNCH;
                    end
                    if (reg_wdata[CB_KILL]) begin
                        d.done = 1'b1;
                        d.idx  = '0;
                        d.fail = 1'b1;
                        d.busy = 1'b0;
                        d.i2c  = 1'b0;
                        d.st   = ST_IDLE;
                    end
                end
                RA_CNT: d.cnt = reg_wdata;
                RA_OFS: d.ofs = reg_wdata;
                RA_BDAT: begin
                    if (q.aux[AB_BUF]) begin
                        mem_we    = 1'b1;
                        mem_waddr = q.idx;
                        mem_wdata = reg_wdata;
                        d.idx     = idx_nx;
                    end else begin
                        d.hold = reg_wdata;
                    end
                end
                RA_AUX: d.aux = reg_wdata[1:0];
                default: ;
            endcase
        end

        // buffered drain through block-data reads
        if (reg_rd && (reg_addr == RA_BDAT) && q.aux[AB_BUF] && !q.i2c) begin
            d.idx = idx_nx;
            if (!q.done && hit_nx) begin
                d.done = 1'b1;
                d.idx  = '0;
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.done <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_idx     = q.idx;
    assign rd_idx_nx  = idx_nx;
    assign sts_o      = {q.bdone, 3'b000, q.fail, q.derr, q.intr, q.busy};
    assign ctl_o      = q.ctl;
    assign cnt_o      = q.cnt;
    assign ofs_o      = q.ofs;
    assign hold_o     = q.hold;
    assign aux_o      = q.aux;
    assign blk_path_o = q.aux[AB_BUF] && !q.i2c;

    // R1: only the two auxiliary bits are kept
    assert_aux_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_AUX) |=> (q.aux == $past(reg_wdata[1:0])));

    // R4: busy stays high for every non-idle sequencer step
    assert_busy_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> q.busy);

    // R4: an acknowledged final send completes the operation
    assert_send_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op == BOP_SEND && bus_last && bus_ack && !reg_wr)
        |=> (q.intr && !q.busy && q.done));

    // R11: kill ends the operation in one cycle
    assert_kill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CTL && reg_wdata[CB_KILL])
        |=> (q.fail && !q.busy && q.done && q.st == ST_IDLE));

    // R12: a clear of byte-done while finished leaves the index alone
    assert_stray_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_STS && q.done && q.st == ST_IDLE)
        |=> $stable(q.idx));
endmodule

// File: rtl/smbseq_top.sv
module smbseq_top
    import smbseq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       bus_req,
    output logic [2:0] bus_op,
    output logic [7:0] bus_wdata,
    output logic       bus_last,
    input  logic       bus_ack,
    input  logic [7:0] bus_rdata
);
    localparam int IW = $clog2(DEPTH);

    logic          mem_we;
    logic [IW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] rd_idx_nx;
    logic [7:0]    buf_a;
    logic [7:0]    buf_b;
    bus_op_e       op_e;
    logic [7:0]    sts;
    logic [4:0]    ctl;
    logic [7:0]    cnt;
    logic [7:0]    ofs;
    logic [7:0]    hold;
    logic [1:0]    aux;
    logic          blk_path;

    smbseq_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (rd_idx),
        .raddr_b (rd_idx_nx),
        .rdata_a (buf_a),
        .rdata_b (buf_b)
    );

    smbseq_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .buf_a      (buf_a),
        .buf_b      (buf_b),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .rd_idx     (rd_idx),
        .rd_idx_nx  (rd_idx_nx),
        .bus_req    (bus_req),
        .bus_op     (op_e),
        .bus_wdata  (bus_wdata),
        .bus_last   (bus_last),
        .sts_o      (sts),
        .ctl_o      (ctl),
        .cnt_o      (cnt),
        .ofs_o      (ofs),
        .hold_o     (hold),
        .aux_o      (aux),
        .blk_path_o (blk_path)
    );

    assign bus_op = op_e;

    always_comb begin
        case (reg_addr)
            RA_STS:  reg_rdata = sts;
            RA_CTL:  reg_rdata = {3'b000, ctl};
            RA_CNT:  reg_rdata = cnt;
            RA_OFS:  reg_rdata = ofs;
            RA_BDAT: reg_rdata = blk_path ? buf_a : hold;
            RA_AUX:  reg_rdata = {6'b000000, aux};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq = ctl[CB_IEN] &&
                 (sts[SB_INTR] || sts[SB_DERR] || sts[SB_FAIL] || sts[SB_BDONE]);
endmodule

// File: tb/smbseq_top_tb.sv
module smbseq_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       bus_req;
    logic [2:0] bus_op;
    logic [7:0] bus_wdata;
    logic       bus_last;
    logic       bus_ack = 1'b1;
    logic [7:0] bus_rdata;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] dev_count = 8'd0;
    logic [7:0] dev_bytes [4];
    int         rb_ptr = 0;
    int         rc_ptr = 0;

    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    smbseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_last(bus_last), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // serial engine model: answers in the same cycle
    always_comb begin
        case (bus_op)
            3'd1:    bus_rdata = dev_count;
            3'd2:    bus_rdata = dev_bytes[rb_ptr % 4];
            3'd4:    bus_rdata = 8'hA0 + 8'(rc_ptr);
            default: bus_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (bus_req && bus_op == 3'd1) rb_ptr <= 0;
        if (bus_req && bus_op == 3'd2) rb_ptr <= rb_ptr + 1;
        if (bus_req && bus_op == 3'd4) rc_ptr <= rc_ptr + 1;
    end

    // monitor: compares each bus request with the queued expectation
    always begin
        @(negedge clk);
        #1;
        if (rst_n && bus_req) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL unexpected bus request: actual op=%0d wdata=%02h last=%0d expected none",
                         bus_op, bus_wdata, bus_last);
            end else begin
                automatic logic [11:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if ({bus_op, bus_wdata, bus_last} !== e) begin
                    miscompares++;
                    $display("FAIL %s bus: actual op=%0d wdata=%02h last=%0d expected op=%0d wdata=%02h last=%0d",
                             t, bus_op, bus_wdata, bus_last, e[11:9], e[8:1], e[0]);
                end
            end
        end
    end

    task automatic expect_bus(input string t, input logic [2:0] op,
                              input logic [7:0] wd, input logic last);
        exp_q.push_back({op, wd, last});
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", t, act, exp);
        end
    endtask

    task automatic check_reg(input string t, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(t, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        dev_bytes[0] = 8'h51; dev_bytes[1] = 8'h52;
        dev_bytes[2] = 8'h53; dev_bytes[3] = 8'h54;
        idle(3);
        #1 rst_n = 1'b1;
        idle(2);

        // R13 reset state
        check_reg("R13 reset status", 4'd0, 8'h00);
        check_reg("R13 reset control", 4'd1, 8'h00);
        check("R13 reset irq", {7'd0, irq}, 8'h00);

        // R1 aux keeps two bits
        wr(4'd5, 8'hFF);
        check_reg("R1 aux readback", 4'd5, 8'h03);

        // R2/R4 buffered write of three bytes
        wr(4'd5, 8'h02);
        wr(4'd4, 8'h11); wr(4'd4, 8'h22); wr(4'd4, 8'h33);
        wr(4'd2, 8'd3);
        expect_bus("R4", 3'd0, 8'h11, 1'b0);
        expect_bus("R2", 3'd0, 8'h22, 1'b0);
        expect_bus("R4", 3'd0, 8'h33, 1'b1);
        wr(4'd1, 8'h41);
        idle(8);
        check_reg("R4 buffered write done", 4'd0, 8'h02);
        check("R13 irq on interrupt", {7'd0, irq}, 8'h01);
        wr(4'd0, 8'hFF);
        check_reg("R13 status cleared", 4'd0, 8'h00);

        // R4 count mismatch, then index back at 0
        wr(4'd4, 8'h01); wr(4'd4, 8'h02);
        wr(4'd2, 8'd3);
        wr(4'd1, 8'h40);
        idle(4);
        check_reg("R4 mismatch error", 4'd0, 8'h04);
        wr(4'd0, 8'hFF);
        wr(4'd4, 8'hAA);
        wr(4'd2, 8'd1);
        expect_bus("R4", 3'd0, 8'hAA, 1'b1);
        wr(4'd1, 8'h40);
        idle(6);
        check_reg("R4 after index reset", 4'd0, 8'h02);
        wr(4'd0, 8'hFF);

        // R13 error blocks a start
        wr(4'd1, 8'h40);
        idle(4);
        check_reg("R13 error set", 4'd0, 8'h04);
        wr(4'd1, 8'h40);
        idle(4);
        check_reg("R13 start blocked", 4'd0, 8'h04);
        wr(4'd0, 8'hFF);

        // R3 index wrap: 33 writes, entry 0 holds the last
        for (int i = 0; i < 33; i++) wr(4'd4, 8'(i));
        wr(4'd2, 8'd1);
        expect_bus("R3", 3'd0, 8'h20, 1'b1);
        wr(4'd1, 8'h40);
        idle(6);
        check_reg("R3 wrap send done", 4'd0, 8'h02);
        wr(4'd0, 8'hFF);

        // R5 buffered read
        dev_count = 8'd3;
        expect_bus("R5", 3'd1, 8'h00, 1'b0);
        expect_bus("R5", 3'd2, 8'h00, 1'b0);
        expect_bus("R5", 3'd2, 8'h00, 1'b0);
        expect_bus("R5", 3'd2, 8'h00, 1'b1);
        wr(4'd1, 8'h50);
        idle(10);
        check_reg("R5 fill status", 4'd0, 8'h03);
        check_reg("R5 count stored", 4'd2, 8'h03);
        check_reg("R5 byte 0", 4'd4, 8'h51);
        check_reg("R5 byte 1", 4'd4, 8'h52);
        check_reg("R5 still busy", 4'd0, 8'h03);
        check_reg("R5 byte 2", 4'd4, 8'h53);
        check_reg("R5 busy cleared", 4'd0, 8'h02);
        wr(4'd0, 8'hFF);

        // R14 oversize count
        dev_count = 8'd40;
        expect_bus("R14", 3'd1, 8'h00, 1'b0);
        wr(4'd1, 8'h50);
        idle(6);
        check_reg("R14 oversize error", 4'd0, 8'h04);
        wr(4'd0, 8'hFF);

        // R6/R7 byte-by-byte write
        wr(4'd5, 8'h00);
        wr(4'd4, 8'h61);
        wr(4'd2, 8'd2);
        wr(4'd1, 8'h41);
        idle(4);
        check_reg("R6 start flags", 4'd0, 8'h81);
        wr(4'd4, 8'h62);
        check_reg("R2 holding readback", 4'd4, 8'h62);
        wr(4'd0, 8'h80);
        check_reg("R7 byte-done again", 4'd0, 8'h81);
        expect_bus("R7", 3'd0, 8'h61, 1'b0);
        expect_bus("R7", 3'd0, 8'h62, 1'b1);
        wr(4'd0, 8'h80);
        idle(6);
        check_reg("R7 write complete", 4'd0, 8'h02);

        // R12 stray clear while finished
        wr(4'd0, 8'h80);
        idle(4);
        check_reg("R12 stray clear ignored", 4'd0, 8'h02);
        wr(4'd0, 8'hFF);

        // R8 byte-by-byte read
        dev_count = 8'd3;
        dev_bytes[0] = 8'h71; dev_bytes[1] = 8'h72; dev_bytes[2] = 8'h73;
        expect_bus("R8", 3'd1, 8'h00, 1'b0);
        expect_bus("R8", 3'd2, 8'h00, 1'b0);
        expect_bus("R8", 3'd2, 8'h00, 1'b0);
        expect_bus("R8", 3'd2, 8'h00, 1'b1);
        wr(4'd1, 8'h50);
        idle(10);
        check_reg("R8 first status", 4'd0, 8'h81);
        check_reg("R8 first byte", 4'd4, 8'h71);
        wr(4'd0, 8'h80);
        check_reg("R8 second byte", 4'd4, 8'h72);
        check_reg("R6 advance status", 4'd0, 8'h81);
        wr(4'd1, 8'h14);
        wr(4'd0, 8'h80);
        check_reg("R8 last byte", 4'd4, 8'h73);
        check_reg("R8 ended", 4'd0, 8'h02);
        wr(4'd0, 8'hFF);

        // R9 I2C block read, direction bit clear
        wr(4'd3, 8'h09);
        expect_bus("R9", 3'd3, 8'h09, 1'b0);
        expect_bus("R9", 3'd4, 8'h00, 1'b0);
        wr(4'd1, 8'h48);
        idle(6);
        check_reg("R9 first status", 4'd0, 8'h81);
        check_reg("R9 first byte", 4'd4, 8'hA0);
        expect_bus("R9", 3'd4, 8'h00, 1'b0);
        wr(4'd0, 8'h80);
        check_reg("R9 second byte", 4'd4, 8'hA1);
        wr(4'd1, 8'h0C);
        expect_bus("R9", 3'd4, 8'h00, 1'b1);
        wr(4'd0, 8'h80);
        check_reg("R9 nack byte", 4'd4, 8'hA2);
        check_reg("R9 ended", 4'd0, 8'h02);
        wr(4'd0, 8'hFF);

        // R10 restart during I2C read, then R11 kill
        expect_bus("R10", 3'd3, 8'h09, 1'b0);
        expect_bus("R10", 3'd4, 8'h00, 1'b0);
        wr(4'd1, 8'h48);
        idle(6);
        check_reg("R10 i2c running", 4'd0, 8'h81);
        expect_bus("R10", 3'd5, 8'h00, 1'b0);
        wr(4'd1, 8'h40);
        idle(4);
        check_reg("R10 new start", 4'd0, 8'h81);
        wr(4'd1, 8'h02);
        check_reg("R11 kill status", 4'd0, 8'h88);
        wr(4'd0, 8'h80);
        idle(4);
        check_reg("R12 clear after kill", 4'd0, 8'h08);

        idle(4);
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R4 scoreboard: actual %0d requests outstanding expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule